// File: doc/BRIEF.md
# Single-Line Trigger-Selectable Interrupt Controller

This block watches one asynchronous external interrupt pin, which is non-maskable at the system level. It brings the pin into the clock domain through a two-flop synchronizer. It then checks the pin against one of four trigger conditions chosen in software: low level, high level, falling edge or rising edge. When the chosen condition is seen, a pending flag is latched. While the line is enabled, that flag drives a registered interrupt output toward a parent interrupt controller.

Software reaches three registers through a simple single-cycle register bus. The control register holds the trigger selection in its two low bits; all its other bits are plain storage. The pending register is cleared by writing one to it. The enable register gates the output. In the level modes, clearing the pending flag serves as the end-of-interrupt: if the level is still present, the flag comes straight back.

An elaboration parameter picks one of four address arrangements for the three registers. Reads of any other address return zero, and writes to any other address do nothing.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After reset the control, pending and enable registers read 0 and `irq_out` is 0, so the trigger mode is low level.
- R2: Control bits [1:0] select the trigger: 0 = pin low, 1 = falling edge, 2 = pin high, 3 = rising edge. An edge mode keeps the flag after the pin returns, and a steady pin never triggers an edge mode.
- R3: Control bits [31:2] are read/write storage and read back exactly as written, together with bits [1:0].
- R4: Writing a word with bit 0 = 1 to the pending register clears the flag. Writing bit 0 = 0 leaves it unchanged. The pending register reads the flag in bit 0 and zero in bits [31:1].
- R5: The enable register stores bit 0 only and reads zero in bits [31:1]. `irq_out` is the registered AND of the pending flag and the enable bit, one cycle behind them, so it stays 0 while enable is 0.
- R6: In a level mode, a pending clear made while the selected level is still present leaves the flag reading 1 on the next read.
- R7: In an edge mode, an edge detected in the same cycle as a pending clear takes priority, and the flag reads 1 afterwards.
- R8: A pin change is first visible in the pending register after the third rising clock edge, and on `irq_out` after the fourth.
- R9: LAYOUT 0 maps control/pending/enable to 0x00/0x04/0x08. LAYOUT 1 maps them to 0x00/0x08/0x04. LAYOUT 2 maps them to 0x0C/0x10/0x40. LAYOUT 3 maps them to 0x00/0x04/0x34.
- R10: Addresses not mapped by the chosen layout read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| bus_wr | input | 1 | Register write strobe, applied on the rising clock edge |
| bus_addr | input | AW (8) | Byte address of the register access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from `bus_addr` |
| irq_out | output | 1 | Registered interrupt request to the parent controller |

## Verification
Register writes take effect on the clock edge that samples the strobe, so the bench reads back at the next falling edge. Reads are combinational and are sampled one nanosecond after the address is driven. A pin change needs three rising edges to reach the pending flag and four to reach `irq_out`. The directed latency checks step one falling edge at a time and verify that neither result appears early. The edge-versus-clear race is set up so that the clear write lands on the same edge as the detection. The random phase compares every cycle against a cycle model in the bench. That model advances on the same edges as the design, so every comparison is due in exactly that cycle.

// File: rtl/nmi_line_ctrl.sv
`timescale 1ns/1ps
module nmi_line_ctrl #(
  parameter int LAYOUT     = 0,
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter bit IDLE_LEVEL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_pin,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_out
);

  localparam logic [AW-1:0] CTRL_OFS = (LAYOUT == 2) ? AW'(12) : AW'(0);
  localparam logic [AW-1:0] PEND_OFS = (LAYOUT == 1) ? AW'(8)  :
                                       (LAYOUT == 2) ? AW'(16) : AW'(4);
  localparam logic [AW-1:0] EN_OFS   = (LAYOUT == 0) ? AW'(8)  :
                                       (LAYOUT == 1) ? AW'(4)  :
                                       (LAYOUT == 2) ? AW'(64) : AW'(52);

  localparam logic [1:0] TRIG_LOW  = 2'd0;
  localparam logic [1:0] TRIG_FALL = 2'd1;
  localparam logic [1:0] TRIG_HIGH = 2'd2;

  logic [1:0]    sync_q;
  logic          prev_q;
  logic          pend_q;
  logic          en_q;
  logic [DW-1:0] ctrl_q;
  logic          trig_hit;

  wire smp      = sync_q[1];
  wire hit_ctrl = (bus_addr == CTRL_OFS);
  wire hit_pend = (bus_addr == PEND_OFS);
  wire hit_en   = (bus_addr == EN_OFS);
  wire clr_req  = bus_wr & hit_pend & bus_wdata[0];

  always_comb begin
    case (ctrl_q[1:0])
      TRIG_LOW:  trig_hit = ~smp;
      TRIG_FALL: trig_hit = prev_q & ~smp;
      TRIG_HIGH: trig_hit = smp;
      default:   trig_hit = ~prev_q & smp;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{IDLE_LEVEL}};
      prev_q <= IDLE_LEVEL;
    end else begin
      sync_q <= {sync_q[0], irq_pin};
      prev_q <= smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      en_q    <= 1'b0;
      ctrl_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      pend_q  <= trig_hit | (pend_q & ~clr_req);
      irq_out <= pend_q & en_q;
      if (bus_wr && hit_ctrl) ctrl_q <= bus_wdata;
      if (bus_wr && hit_en)   en_q   <= bus_wdata[0];
    end
  end

  always_comb begin
    if (hit_ctrl)      bus_rdata = ctrl_q;
    else if (hit_pend) bus_rdata = DW'(pend_q);
    else if (hit_en)   bus_rdata = DW'(en_q);
    else               bus_rdata = '0;
  end

  // R5
  en_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_out);

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_pend && bus_wdata[0] && !trig_hit) |=> !pend_q);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(bus_wr && hit_pend && bus_wdata[0])) |=> pend_q);

  // R6
  level_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && trig_hit) |=> pend_q);

  // R7
  edge_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && trig_hit) |=> pend_q);

  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_ctrl && !hit_pend && !hit_en) |=> ($stable(ctrl_q) && $stable(en_q)));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ctrl && !hit_pend && !hit_en) |-> (bus_rdata == '0));

endmodule

// File: tb/sim_nmi_line_ctrl.sv
`timescale 1ns/1ps
module sim_nmi_line_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic [3:0]  wr_l = 4'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] rd0, rd1, rd2, rd3;
  logic        irq0, irq1, irq2, irq3;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  nmi_line_ctrl #(.LAYOUT(0)) u0 (.clk(clk), .rst_n(rst_n), .irq_pin(pin), .bus_wr(wr_l[0]),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd0), .irq_out(irq0));
  nmi_line_ctrl #(.LAYOUT(1)) u1 (.clk(clk), .rst_n(rst_n), .irq_pin(pin), .bus_wr(wr_l[1]),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd1), .irq_out(irq1));
  nmi_line_ctrl #(.LAYOUT(2)) u2 (.clk(clk), .rst_n(rst_n), .irq_pin(pin), .bus_wr(wr_l[2]),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd2), .irq_out(irq2));
  nmi_line_ctrl #(.LAYOUT(3)) u3 (.clk(clk), .rst_n(rst_n), .irq_pin(pin), .bus_wr(wr_l[3]),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd3), .irq_out(irq3));

  // Cycle model of u0 (layout 0) built from the requirements
  logic        m_s1, m_s2, m_prev, m_pend, m_en, m_irq;
  logic [31:0] m_ctrl;

  function automatic logic exp_trig(input logic [1:0] mode, input logic cur, input logic old);
    case (mode)
      2'd0: return !cur;
      2'd1: return old && !cur;
      2'd2: return cur;
      default: return !old && cur;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return {31'b0, m_pend};
      8'h08: return {31'b0, m_en};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
      m_pend <= 1'b0; m_en <= 1'b0; m_irq <= 1'b0; m_ctrl <= 32'h0;
    end else begin
      m_s1   <= pin;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_pend <= exp_trig(m_ctrl[1:0], m_s2, m_prev) |
                (m_pend & !(wr_l[0] && bus_addr == 8'h04 && bus_wdata[0]));
      m_irq  <= m_pend & m_en;
      if (wr_l[0] && bus_addr == 8'h00) m_ctrl <= bus_wdata;
      if (wr_l[0] && bus_addr == 8'h08) m_en <= bus_wdata[0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_write(input logic [3:0] mask, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_l = mask; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    wr_l = 4'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    bus_addr = a;
    #1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    set_addr(8'h00); chk("R1 ctrl", rd0, 32'h0);
    set_addr(8'h04); chk("R1 pend", rd0, 32'h0);
    set_addr(8'h08); chk("R1 en", rd0, 32'h0);
    chk("R1 irq", {31'b0, irq0}, 32'h0);

    // R3 full control storage, rising mode selected
    bus_write(4'b0001, 8'h00, 32'hA5A5_5A03);
    set_addr(8'h00); chk("R3 ctrl readback", rd0, 32'hA5A5_5A03);
    tick(3);
    set_addr(8'h04); chk("R2 steady pin no edge", rd0, 32'h0);

    // R5 enable stores bit 0 only
    bus_write(4'b0001, 8'h08, 32'hFFFF_FFFF);
    set_addr(8'h08); chk("R5 en bit0 only", rd0, 32'h1);

    // R2 falling edge ignored in rising mode
    pin = 1'b0; tick(5);
    set_addr(8'h04); chk("R2 fall in rise mode", rd0, 32'h0);

    // R8 latency of a rising edge
    @(negedge clk); pin = 1'b1; set_addr(8'h04);
    @(negedge clk); #1 chk("R8 pend after 1 edge", rd0, 32'h0);
    @(negedge clk); #1 chk("R8 pend after 2 edges", rd0, 32'h0);
    @(negedge clk); #1 chk("R8 pend after 3 edges", rd0, 32'h1);
    chk("R8 irq after 3 edges", {31'b0, irq0}, 32'h0);
    @(negedge clk); #1 chk("R8 irq after 4 edges", {31'b0, irq0}, 32'h1);

    // R4 write-one-to-clear
    bus_write(4'b0001, 8'h04, 32'hFFFF_FFFE);
    set_addr(8'h04); chk("R4 write 0 no effect", rd0, 32'h1);
    bus_write(4'b0001, 8'h04, 32'h1);
    set_addr(8'h04); chk("R4 write 1 clears", rd0, 32'h0);
    tick(2);
    chk("R5 irq drops after clear", {31'b0, irq0}, 32'h0);

    // R6 level high re-asserts after clear
    bus_write(4'b0001, 8'h00, 32'h0000_0002);
    tick(1);
    set_addr(8'h04); chk("R2 level high sets", rd0, 32'h1);
    bus_write(4'b0001, 8'h04, 32'h1);
    set_addr(8'h04); chk("R6 level still high re-sets", rd0, 32'h1);
    pin = 1'b0; tick(4);
    bus_write(4'b0001, 8'h04, 32'h1);
    tick(2);
    set_addr(8'h04); chk("R6 level gone clears", rd0, 32'h0);

    // R2 falling edge mode
    bus_write(4'b0001, 8'h00, 32'h0000_0001);
    pin = 1'b1; tick(4);
    set_addr(8'h04); chk("R2 rise in fall mode", rd0, 32'h0);
    pin = 1'b0; tick(4);
    set_addr(8'h04); chk("R2 falling edge sets", rd0, 32'h1);
    pin = 1'b1; tick(4);
    set_addr(8'h04); chk("R2 edge flag held", rd0, 32'h1);
    bus_write(4'b0001, 8'h04, 32'h1);

    // R5 masking with level low
    bus_write(4'b0001, 8'h08, 32'h0);
    bus_write(4'b0001, 8'h00, 32'h0);
    pin = 1'b0; tick(5);
    set_addr(8'h04); chk("R2 level low sets", rd0, 32'h1);
    chk("R5 masked irq low", {31'b0, irq0}, 32'h0);
    bus_write(4'b0001, 8'h08, 32'h1);
    chk("R5 irq one cycle late", {31'b0, irq0}, 32'h0);
    tick(1);
    chk("R5 irq after enable", {31'b0, irq0}, 32'h1);

    // R7 edge coinciding with clear
    bus_write(4'b0001, 8'h00, 32'h0000_0003);
    bus_write(4'b0001, 8'h04, 32'h1);
    set_addr(8'h04); chk("R4 clear in rise mode", rd0, 32'h0);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_l = 4'b0001; bus_addr = 8'h04; bus_wdata = 32'h1;
    @(negedge clk); wr_l = 4'b0;
    set_addr(8'h04); chk("R7 edge wins over clear", rd0, 32'h1);

    // R10 unmapped accesses on layout 0
    bus_write(4'b0001, 8'h0C, 32'hFFFF_FFFF);
    bus_write(4'b0001, 8'h34, 32'hFFFF_FFFF);
    set_addr(8'h0C); chk("R10 unmapped reads 0", rd0, 32'h0);
    set_addr(8'h00); chk("R10 ctrl untouched", rd0, 32'h0000_0003);
    set_addr(8'h08); chk("R10 en untouched", rd0, 32'h1);

    // R9 layouts 1..3 (pin high and stable, rising mode)
    tick(4);
    bus_write(4'b0010, 8'h00, 32'h1234_5603);
    bus_write(4'b0010, 8'h08, 32'h1);
    bus_write(4'b0010, 8'h04, 32'h1);
    set_addr(8'h00); chk("R9 L1 ctrl", rd1, 32'h1234_5603);
    set_addr(8'h04); chk("R9 L1 en", rd1, 32'h1);
    set_addr(8'h08); chk("R9 L1 pend", rd1, 32'h0);
    bus_write(4'b0100, 8'h0C, 32'h0000_0A03);
    bus_write(4'b0100, 8'h10, 32'h1);
    bus_write(4'b0100, 8'h40, 32'h1);
    set_addr(8'h0C); chk("R9 L2 ctrl", rd2, 32'h0000_0A03);
    set_addr(8'h10); chk("R9 L2 pend", rd2, 32'h0);
    set_addr(8'h40); chk("R9 L2 en", rd2, 32'h1);
    set_addr(8'h00); chk("R10 L2 0x00 unmapped", rd2, 32'h0);
    bus_write(4'b1000, 8'h00, 32'h0077_0003);
    bus_write(4'b1000, 8'h04, 32'h1);
    bus_write(4'b1000, 8'h34, 32'h1);
    set_addr(8'h00); chk("R9 L3 ctrl", rd3, 32'h0077_0003);
    set_addr(8'h04); chk("R9 L3 pend", rd3, 32'h0);
    set_addr(8'h34); chk("R9 L3 en", rd3, 32'h1);
    set_addr(8'h08); chk("R10 L3 0x08 unmapped", rd3, 32'h0);
    pin = 1'b0; tick(4); pin = 1'b1; tick(4);
    set_addr(8'h08); chk("R9 L1 pend addr", rd1, 32'h1);
    set_addr(8'h10); chk("R9 L2 pend addr", rd2, 32'h1);
    set_addr(8'h04); chk("R9 L3 pend addr", rd3, 32'h1);

    // Random phase on u0 against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 5) == 0) pin = ~pin;
      wr_l = (($urandom % 4) == 0) ? 4'b0001 : 4'b0000;
      case ($urandom % 5)
        0: bus_addr = 8'h00;
        1: bus_addr = 8'h04;
        2: bus_addr = 8'h08;
        3: bus_addr = 8'h0C;
        default: bus_addr = 8'h3C;
      endcase
      bus_wdata = $urandom;
      #1;
      chk("R2 R4 rand rdata", rd0, exp_rd(bus_addr));
      chk("R5 rand irq", {31'b0, irq0}, {31'b0, m_irq});
    end
    wr_l = 4'b0;
    tick(2);
    finish_run();
  end
endmodule